// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopbacks

This block is the byte-to-bit datapath of a serial line interface. All of its logic runs on one bit-rate clock. A free-running divide-by-eight counter produces one-cycle byte strobes, and these strobes take the place of separate byte clocks. On the transmit side, a byte and its parity bit are captured on a strobe and shifted out one bit per clock, most significant bit first. The parity of each captured byte is checked and a mismatch is reported one byte period later. On the receive side, the serial input is shifted into a byte on free-running byte boundaries. The byte then passes through a short byte-rate pipeline and is presented together with a generated parity bit.

Two loopback controls steer the serial paths. Facility loopback sends the retimed serial input back out of the serial output, while the receive side keeps deserializing that same input. Equipment loopback feeds the internal transmit bit stream into the deserializer in place of the serial input, and the serial output keeps carrying transmit data. With both controls set, the block is in split mode: line data is turned around at the serial side, and host bytes are turned around at the byte side.

Top module: `serdes_loop_top`

## Requirements
- R1: After reset is released, `tx_strobe` is high for exactly one cycle in every 8. It first goes high in the 7th cycle after reset release. `rx_strobe` follows the same cycles when `RX_OFFSET` = 0.
- R2: Bits [7:0] of `tx_byte` are captured at the clock edge that ends a `tx_strobe` cycle. Bit 7 drives `ser_out` from the next edge on, and bits 6 down to 0 follow on successive cycles. This holds with `fac_lb` = 0.
- R3: With `fac_lb` = 1, a bit presented on `ser_in` in cycle n appears on `ser_out` in cycle n+2. Transmit bytes are then not sent.
- R4: With `eq_lb` = 1 and `fac_lb` = 0, the receive bytes are the transmit bytes, and `ser_out` still carries the serialized transmit bytes.
- R5: With both loopback controls set, `ser_out` follows `ser_in` with the 2-cycle timing of R3, and `rx_byte` carries the transmit bytes with the timing of R4.
- R6: `tx_perr` is updated only at edges that end a `tx_strobe` cycle. It goes to 1 when the `tx_par` captured one byte period earlier differs from the XOR of the 8 bits captured with it. An odd number of ones therefore expects `tx_par` = 1. Otherwise it goes to 0.
- R7: `rx_par` equals the XOR of the 8 bits on `rx_byte` and changes together with it. An odd number of ones gives 1.
- R8: Consider a byte whose MSB is sampled from `ser_in` at the edge that ends an `rx_strobe` cycle. It is presented on `rx_byte` 8×`RX_STAGES` clocks after that edge, which is 32 clocks by default. `rx_byte` changes only at edges that end an `rx_strobe` cycle.
- R9: While `rst` is high and directly after it, `ser_out`, `rx_byte`, `rx_par` and `tx_perr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| fac_lb | input | 1 | Facility loopback: serial input turned around to serial output |
| eq_lb | input | 1 | Equipment loopback: transmit stream fed to the deserializer |
| tx_byte | input | 8 | Transmit byte, captured at the end of a `tx_strobe` cycle |
| tx_par | input | 1 | Even parity bit supplied with `tx_byte` |
| tx_perr | output | 1 | Transmit parity mismatch, reported one byte period late |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| ser_out | output | 1 | Serial output, MSB first |
| ser_in | input | 1 | Serial input |
| rx_byte | output | 8 | Deserialized receive byte |
| rx_par | output | 1 | Even parity of `rx_byte` |
| rx_strobe | output | 1 | One-cycle receive byte strobe |

## Verification
The bench builds the block with `RX_STAGES` = 4 and `RX_OFFSET` = 0. With a zero offset, the receive and transmit byte boundaries coincide. As a result, a byte driven on `ser_in`, starting in a strobe cycle, and a looped-back transmit byte both land whole on the receive boundary, and both come out 33 cycles after being driven. This lets the scoreboard predict every serial bit, receive byte, receive parity bit and parity-error flag in all four routings. Mode changes happen only after the pipelines have drained.

// File: rtl/serdes_pkg.sv
package serdes_pkg;

    parameter int SYM_W = 8;

    typedef struct packed {
        logic [SYM_W-1:0] data;
        logic             par;
    } rx_word_t;

    typedef enum logic [1:0] {
        RT_NORMAL    = 2'b00,
        RT_FACILITY  = 2'b01,
        RT_EQUIPMENT = 2'b10,
        RT_SPLIT     = 2'b11
    } route_t;

    function automatic logic odd_ones(input logic [SYM_W-1:0] v);
        return ^v;
    endfunction

    function automatic route_t route_of(input logic fac, input logic eq);
        return route_t'({eq, fac});
    endfunction

    function automatic logic turns_line(input route_t r);
        return (r == RT_FACILITY) || (r == RT_SPLIT);
    endfunction

    function automatic logic turns_host(input route_t r);
        return (r == RT_EQUIPMENT) || (r == RT_SPLIT);
    endfunction

endpackage

// File: rtl/sd_strobe_gen.sv
module sd_strobe_gen #(
    parameter int PERIOD    = 8,
    parameter int RX_OFFSET = 0
) (
    input  logic clk,
    input  logic rst,
    output logic tx_stb,
    output logic rx_stb
);
    localparam int CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int LAST  = PERIOD - 1;
    localparam int RX_AT = (LAST + RX_OFFSET) % PERIOD;

    logic [CW-1:0] cnt;
    logic [CW:0]   gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(LAST)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx_stb = (cnt == CW'(LAST));
    assign rx_stb = (cnt == CW'(RX_AT));

    // independent spacing counter for the checker
    always_ff @(posedge clk) begin
        if (rst || tx_stb) gap <= '0;
        else               gap <= gap + 1'b1;
    end

    assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (rst)
        tx_stb |-> (gap == (CW+1)'(LAST)));
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        tx_stb |=> !tx_stb);

endmodule

// File: rtl/sd_tx_ser.sv
module sd_tx_ser
    import serdes_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_stb,
    input  logic [SYM_W-1:0] tx_byte,
    input  logic             tx_par,
    output logic             tx_bit,
    output logic             perr
);
    logic [SYM_W-1:0] shreg;
    logic [SYM_W-1:0] held;
    logic             held_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            held     <= '0;
            held_par <= 1'b0;
            perr     <= 1'b0;
        end else if (ld_stb) begin
            shreg    <= tx_byte;
            held     <= tx_byte;
            held_par <= tx_par;
            perr     <= (odd_ones(held) != held_par);
        end else begin
            shreg    <= {shreg[SYM_W-2:0], 1'b0};
        end
    end

    assign tx_bit = shreg[SYM_W-1];

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        ld_stb |=> (tx_bit == $past(tx_byte[SYM_W-1])));
    assert_perr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ld_stb |=> $stable(perr));

endmodule

// File: rtl/sd_rx_deser.sv
module sd_rx_deser
    import serdes_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_stb,
    input  logic     ser_bit,
    output rx_word_t word
);
    logic [SYM_W-1:0] sh;
    logic [SYM_W-1:0] assembled;
    rx_word_t         pipe [STAGES];

    assign assembled = {sh[SYM_W-2:0], ser_bit};

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= assembled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else if (cap_stb) begin
            pipe[0] <= '{data: assembled, par: odd_ones(assembled)};
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign word = pipe[STAGES-1];

    assert_rx_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(word));
    assert_rx_parity_R7: assert property (@(posedge clk) disable iff (rst)
        word.par == odd_ones(word.data));

endmodule

// File: rtl/sd_loop_route.sv
module sd_loop_route
    import serdes_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fac_lb,
    input  logic eq_lb,
    input  logic ser_in,
    input  logic tx_bit,
    output logic ser_out,
    output logic rx_src
);
    route_t route;
    logic   in_q;

    assign route = route_of(fac_lb, eq_lb);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q    <= 1'b0;
            ser_out <= 1'b0;
        end else begin
            in_q    <= ser_in;
            ser_out <= turns_line(route) ? in_q : tx_bit;
        end
    end

    assign rx_src = turns_host(route) ? tx_bit : in_q;

    assert_fac_path_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(fac_lb) && !$past(rst) && !$past(rst, 2)) |-> (ser_out == $past(ser_in, 2)));
    assert_eq_tx_out_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!fac_lb) && !$past(rst)) |-> (ser_out == $past(tx_bit)));

endmodule

// File: rtl/serdes_loop_top.sv
module serdes_loop_top
    import serdes_pkg::*;
#(
    parameter int RX_STAGES = 4,
    parameter int RX_OFFSET = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fac_lb,
    input  logic             eq_lb,
    input  logic [SYM_W-1:0] tx_byte,
    input  logic             tx_par,
    output logic             tx_perr,
    output logic             tx_strobe,
    output logic             ser_out,
    input  logic             ser_in,
    output logic [SYM_W-1:0] rx_byte,
    output logic             rx_par,
    output logic             rx_strobe
);
    logic     tx_bit;
    logic     rx_src;
    rx_word_t rx_word;

    sd_strobe_gen #(.PERIOD(SYM_W), .RX_OFFSET(RX_OFFSET)) u_stb (
        .clk(clk), .rst(rst), .tx_stb(tx_strobe), .rx_stb(rx_strobe)
    );

    sd_tx_ser u_tx (
        .clk(clk), .rst(rst), .ld_stb(tx_strobe), .tx_byte(tx_byte),
        .tx_par(tx_par), .tx_bit(tx_bit), .perr(tx_perr)
    );

    sd_loop_route u_route (
        .clk(clk), .rst(rst), .fac_lb(fac_lb), .eq_lb(eq_lb), .ser_in(ser_in),
        .tx_bit(tx_bit), .ser_out(ser_out), .rx_src(rx_src)
    );

    sd_rx_deser #(.STAGES(RX_STAGES)) u_rx (
        .clk(clk), .rst(rst), .cap_stb(rx_strobe), .ser_bit(rx_src), .word(rx_word)
    );

    assign rx_byte = rx_word.data;
    assign rx_par  = rx_word.par;

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!tx_perr && !ser_out && (rx_byte == '0)));

endmodule

// File: tb/test_serdes_loop_top.sv
`timescale 1ns/1ps
module test_serdes_loop_top;
    localparam int STG = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fac_lb = 1'b0, eq_lb = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_par = 1'b0;
    logic       ser_in = 1'b0;
    logic       tx_perr, tx_strobe, ser_out, rx_par, rx_strobe;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_stb = -1;
    int rel_cyc  = 0;
    bit first_seen = 0;

    typedef struct {
        int         due;
        int         req;
        logic [7:0] v;
        logic       p;
    } exp_t;

    exp_t ser_q[$];
    exp_t rx_q[$];
    exp_t pe_q[$];

    always #2.5 clk = ~clk;

    serdes_loop_top #(.RX_STAGES(STG), .RX_OFFSET(0)) i_serdes_loop_top (
        .clk(clk), .rst(rst), .fac_lb(fac_lb), .eq_lb(eq_lb),
        .tx_byte(tx_byte), .tx_par(tx_par), .tx_perr(tx_perr), .tx_strobe(tx_strobe),
        .ser_out(ser_out), .ser_in(ser_in), .rx_byte(rx_byte), .rx_par(rx_par),
        .rx_strobe(rx_strobe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d cyc=%0d actual=%0h expected=%0h", req, cyc, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        while (ser_q.size() > 0 && ser_q[0].due <= cyc) begin
            e = ser_q.pop_front();
            chk(ser_out === e.v[0] && e.due == cyc, e.req, int'(ser_out), int'(e.v[0]));
        end
        while (rx_q.size() > 0 && rx_q[0].due <= cyc) begin
            e = rx_q.pop_front();
            chk(rx_byte === e.v && e.due == cyc, e.req, int'(rx_byte), int'(e.v));
            chk(rx_par === e.p, 7, int'(rx_par), int'(e.p));  // R7 parity
        end
        while (pe_q.size() > 0 && pe_q[0].due <= cyc) begin
            e = pe_q.pop_front();
            chk(tx_perr === e.v[0] && e.due == cyc, 6, int'(tx_perr), int'(e.v[0]));  // R6
        end
        // R1 strobe spacing
        if (rst) begin
            last_stb = -1;
        end else begin
            chk(rx_strobe === tx_strobe, 1, int'(rx_strobe), int'(tx_strobe));
            if (tx_strobe === 1'b1) begin
                if (last_stb >= 0) chk(cyc - last_stb == 8, 1, cyc - last_stb, 8);
                else if (!first_seen) begin
                    chk(cyc == rel_cyc + 7, 1, cyc - rel_cyc, 7);  // R1 first strobe
                    first_seen = 1;
                end
                last_stb = cyc;
            end
        end
    end

    task automatic send(input logic [7:0] tb, input bit bad, input logic [7:0] sb);
        int c;
        logic [7:0] d;
        while (tx_strobe !== 1'b1) @(negedge clk);
        c = cyc;
        tx_byte = tb;
        tx_par  = (^tb) ^ bad;
        for (int k = 0; k < 8; k++) begin
            // R2 transmit bits / R3 R5 line turnaround
            ser_q.push_back('{due: c + 2 + k, req: (fac_lb ? (eq_lb ? 5 : 3) : 2),
                              v: {7'b0, (fac_lb ? sb[7-k] : tb[7-k])}, p: 1'b0});
        end
        d = eq_lb ? tb : sb;  // R4 R5 host turnaround, R8 latency
        rx_q.push_back('{due: c + 1 + 8*STG, req: (eq_lb ? (fac_lb ? 5 : 4) : 8),
                         v: d, p: ^d});
        pe_q.push_back('{due: c + 9, req: 6, v: {7'b0, bad}, p: 1'b0});
        for (int k = 0; k < 8; k++) begin
            ser_in = sb[7-k];
            @(negedge clk);
        end
    endtask

    task automatic flush();
        repeat (48) @(negedge clk);
    endtask

    task automatic burst();
        send(8'hA5, 0, 8'h3C);
        send(8'h01, 1, 8'h81);
        send(8'hFF, 0, 8'h07);
        send(8'h80, 1, 8'hE0);
        send(8'h6B, 0, 8'h00);
        send(8'h00, 0, 8'hFE);
    endtask

    initial begin
        #500000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset values while held
        chk(ser_out === 1'b0 && tx_perr === 1'b0, 9, int'({ser_out, tx_perr}), 0);
        chk(rx_byte === 8'h00 && rx_par === 1'b0, 9, int'(rx_byte), 0);
        rst = 1'b0;
        rel_cyc = cyc;
        @(negedge clk);
        chk(ser_out === 1'b0 && rx_byte === 8'h00, 9, int'(rx_byte), 0);
        burst();                       // normal routing: R2 R6 R7 R8
        flush();
        fac_lb = 1'b1;                 // R3
        burst();
        flush();
        fac_lb = 1'b0; eq_lb = 1'b1;   // R4
        burst();
        flush();
        fac_lb = 1'b1;                 // R5 split
        burst();
        flush();
        fac_lb = 1'b0; eq_lb = 1'b0;
        send(8'h5A, 1, 8'hC3);
        send(8'h7F, 0, 8'h10);
        flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule